// File: doc/BRIEF.md
# Port Access Permission Checker

This block rules on whether a task may touch an I/O port. A request gives the 16-bit port number, the access size in bytes, the current privilege level, the I/O privilege level, a flag that marks a virtual-8086 task, and the task-state segment limit. If the privilege levels already allow the access, the block grants it at once. Otherwise it reads the task-state segment to find the permission bitmap and checks the bits that cover the port.

Memory reads use a byte-wide read port. The block first reads the 16-bit bitmap base offset, which sits little-endian at byte addresses 66h (low byte) and 67h (high byte). It then reads the two consecutive bitmap bytes that cover the port. Each request ends with a one-cycle `done` pulse, and `grant` tells whether the access was allowed. A fault and a denial both appear as `done` with `grant` low.

Back-pressure rules. A request is taken in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, and that includes the cycle in which `done` is high. A read completes in a cycle where `mem_valid` and `mem_ready` are both high, and `mem_rdata` is sampled in that same cycle. While `mem_ready` is low, `mem_valid` stays high and `mem_addr` holds its value. A strict/permissive switch, `strict_mode`, is sampled when a request is taken.

Top module: `port_perm_check`

## Requirements
- R1: If the task is not virtual-8086 and CPL <= IOPL, the access is granted with no memory reads. `done` and `grant` are high in the cycle after the request is taken.
- R2: A virtual-8086 task never takes the privilege bypass. It always goes through the bitmap, even at CPL 0.
- R3: Every request that consults the bitmap reads the offset field again, first byte 66h and then byte 67h. Nothing is kept from one request to the next.
- R4: If the limit is below 67h on a bitmap path, the request faults with no memory reads, one cycle after it is taken.
- R5: A bitmap bit of 0 allows a port and a bit of 1 denies it. An access of W bytes checks W bits, starting at bit (port mod 8) of byte base + port/8. It is granted only if all of those bits are 0.
- R6: Exactly two bitmap bytes are read, at A = base + port/8 and then A+1, whatever the access size. Bits beyond bit 7 come from the second byte.
- R7: If A+1 is greater than the limit, the access is denied and no bitmap bytes are read.
- R8: A is a 32-bit sum and never wraps at 16 bits. The upper ports check bits in the byte past the bitmap, never in port 0's byte.
- R9: With `strict_mode` = 1, a base below 68h means there is no bitmap and the access is denied after the offset read. With `strict_mode` = 0, the base is used as given.
- R10: `req_width` codes 1, 2 and 4 mean 1, 2 and 4 bytes. Any other code faults with no memory reads.
- R11: `req_ready` is high only when the block is idle. `mem_valid` is never high while the block is idle. A stalled read holds `mem_valid` and `mem_addr`.
- R12: `done` pulses for one cycle for each request taken. `grant` is never high without `done`. After reset, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | 1: a base below 68h means no bitmap; 0: the base is used as given |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle; a request can be taken |
| req_port | input | 16 | Port number |
| req_width | input | 3 | Access size code (1, 2 or 4) |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level |
| req_vm | input | 1 | Task is in virtual-8086 mode |
| req_limit | input | 32 | Task-state segment limit (last valid byte offset) |
| mem_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Read completes this cycle |
| mem_addr | output | 32 | Byte address of the read |
| mem_rdata | input | 8 | Read data, sampled when the read completes |
| done | output | 1 | One-cycle result pulse |
| grant | output | 1 | Access allowed (valid with done) |

## Verification
The bench builds unaligned 4-byte accesses whose bits cross into the next byte. A design that reads only one byte, or shifts by the wrong amount, grants a port that the second byte denies. It checks ports just below FFFFh, with the base both low and high. A 16-bit address sum there reads port 0's byte or the wrong address. It also checks a limit that stops exactly one byte short of the pad, which an off-by-one comparison lets through. Strict and permissive handling of a low base, a VM task at CPL 0, and a base that changes between requests are also covered, because a design that skipped the bitmap or cached the offset would grant wrongly. The reads are stalled throughout, so any address or result that comes a cycle early or late is caught.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_OFS_LO,
    S_OFS_HI,
    S_LOCATE,
    S_MAP_LO,
    S_MAP_HI
  } ppc_state_e;

  // location of the bitmap base field and the minimum limit that covers it
  localparam logic [31:0] OFS_FIELD_ADDR   = 32'h66;
  localparam logic [31:0] MIN_TSS_LIMIT    = 32'h67;
  // size of the fixed region; strict mode treats a lower base as "no bitmap"
  localparam logic [15:0] FIXED_REGION_END = 16'h68;
endpackage

// File: rtl/ppc_pre.sv
// Request pre-decode: size code, privilege bypass, limit too short for the offset field.
module ppc_pre #(
  parameter int WCODE_W = 3,
  parameter int PL_W    = 2,
  parameter int ADDR_W  = 32
) (
  input  logic [WCODE_W-1:0] width,
  input  logic [PL_W-1:0]    cpl,
  input  logic [PL_W-1:0]    iopl,
  input  logic               vm,
  input  logic [ADDR_W-1:0]  limit,
  output logic               bad_width,
  output logic               bypass,
  output logic               short_limit
);
  assign bad_width   = !((width == WCODE_W'(1)) || (width == WCODE_W'(2)) ||
                         (width == WCODE_W'(4)));
  assign bypass      = !vm && (cpl <= iopl);
  assign short_limit = limit < ADDR_W'(ppc_pkg::MIN_TSS_LIMIT);
endmodule

// File: rtl/ppc_locate.sv
// Bitmap byte address and the limit / no-bitmap rejection.
module ppc_locate #(
  parameter int PORT_W = 16,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [OFS_W-1:0]  base,
  input  logic [PORT_W-1:0] port,
  input  logic [ADDR_W-1:0] limit,
  input  logic              strict,
  output logic [ADDR_W-1:0] first_addr,
  output logic              reject
);
  logic [ADDR_W-1:0] second_addr;
  logic              no_map;

  // full-width sum: never wraps at 16 bits
  assign first_addr  = ADDR_W'(base) + ADDR_W'(port[PORT_W-1:3]);
  assign second_addr = first_addr + ADDR_W'(1);
  assign no_map      = strict && (base < OFS_W'(ppc_pkg::FIXED_REGION_END));
  assign reject      = no_map || (second_addr > limit);
endmodule

// File: rtl/ppc_bits.sv
// Extracts the permission window from the two fetched bytes.
module ppc_bits #(
  parameter int WCODE_W = 3,
  parameter int LANES   = 4
) (
  input  logic [7:0]         lo_byte,
  input  logic [7:0]         hi_byte,
  input  logic [2:0]         bit_sel,
  input  logic [WCODE_W-1:0] width,
  output logic               allow
);
  logic [15:0]      pair;
  logic [LANES-1:0] window;
  logic [LANES-1:0] hit;

  assign pair   = {hi_byte, lo_byte};
  assign window = pair[bit_sel +: LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = window[i] && (WCODE_W'(i) < width);
  end

  assign allow = ~|hit;
endmodule

// File: rtl/port_perm_check.sv
module port_perm_check #(
  parameter int PORT_W  = 16,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 16,
  parameter int WCODE_W = 3,
  parameter int PL_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strict_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PORT_W-1:0]  req_port,
  input  logic [WCODE_W-1:0] req_width,
  input  logic [PL_W-1:0]    req_cpl,
  input  logic [PL_W-1:0]    req_iopl,
  input  logic               req_vm,
  input  logic [ADDR_W-1:0]  req_limit,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [7:0]         mem_rdata,
  output logic               done,
  output logic               grant
);
  import ppc_pkg::*;

  ppc_state_e          st;
  logic [PORT_W-1:0]   port_q;
  logic [WCODE_W-1:0]  width_q;
  logic [ADDR_W-1:0]   limit_q;
  logic                strict_q;
  logic [OFS_W-1:0]    base_q;
  logic [ADDR_W-1:0]   map_q;
  logic [7:0]          b0_q;
  logic                done_q;
  logic                grant_q;

  logic                bad_width, bypass, short_limit;
  logic [ADDR_W-1:0]   first_addr;
  logic                reject;
  logic                allow;

  ppc_pre #(.WCODE_W(WCODE_W), .PL_W(PL_W), .ADDR_W(ADDR_W)) u_pre (
    .width(req_width), .cpl(req_cpl), .iopl(req_iopl), .vm(req_vm),
    .limit(req_limit), .bad_width(bad_width), .bypass(bypass),
    .short_limit(short_limit)
  );

  ppc_locate #(.PORT_W(PORT_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_loc (
    .base(base_q), .port(port_q), .limit(limit_q), .strict(strict_q),
    .first_addr(first_addr), .reject(reject)
  );

  ppc_bits #(.WCODE_W(WCODE_W), .LANES(4)) u_bits (
    .lo_byte(b0_q), .hi_byte(mem_rdata), .bit_sel(port_q[2:0]),
    .width(width_q), .allow(allow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      port_q   <= '0;
      width_q  <= '0;
      limit_q  <= '0;
      strict_q <= 1'b0;
      base_q   <= '0;
      map_q    <= '0;
      b0_q     <= '0;
      done_q   <= 1'b0;
      grant_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      grant_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          port_q   <= req_port;
          width_q  <= req_width;
          limit_q  <= req_limit;
          strict_q <= strict_mode;
          if (bad_width) begin
            done_q <= 1'b1;
          end else if (bypass) begin
            done_q  <= 1'b1;
            grant_q <= 1'b1;
          end else if (short_limit) begin
            done_q <= 1'b1;
          end else begin
            st <= S_OFS_LO;
          end
        end
        S_OFS_LO: if (mem_ready) begin
          base_q[7:0] <= mem_rdata;
          st          <= S_OFS_HI;
        end
        S_OFS_HI: if (mem_ready) begin
          base_q[OFS_W-1:8] <= mem_rdata[OFS_W-9:0];
          st                <= S_LOCATE;
        end
        S_LOCATE: begin
          if (reject) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            map_q <= first_addr;
            st    <= S_MAP_LO;
          end
        end
        S_MAP_LO: if (mem_ready) begin
          b0_q <= mem_rdata;
          st   <= S_MAP_HI;
        end
        S_MAP_HI: if (mem_ready) begin
          done_q  <= 1'b1;
          grant_q <= allow;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_addr  = '0;
    case (st)
      S_OFS_LO: begin mem_valid = 1'b1; mem_addr = ADDR_W'(OFS_FIELD_ADDR); end
      S_OFS_HI: begin mem_valid = 1'b1; mem_addr = ADDR_W'(OFS_FIELD_ADDR) + ADDR_W'(1); end
      S_MAP_LO: begin mem_valid = 1'b1; mem_addr = map_q; end
      S_MAP_HI: begin mem_valid = 1'b1; mem_addr = map_q + ADDR_W'(1); end
      default:  begin mem_valid = 1'b0; mem_addr = '0; end
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign done      = done_q;
  assign grant     = grant_q;
endmodule

// File: rtl/ppc_sva.sv
module ppc_sva #(
  parameter int ADDR_W  = 32,
  parameter int WCODE_W = 3,
  parameter int PL_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [WCODE_W-1:0] req_width,
  input logic [PL_W-1:0]    req_cpl,
  input logic [PL_W-1:0]    req_iopl,
  input logic               req_vm,
  input logic [ADDR_W-1:0]  req_limit,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               done,
  input logic               grant
);
  logic take, size_ok, needs_map;
  assign take      = req_valid && req_ready;
  assign size_ok   = (req_width == WCODE_W'(1)) || (req_width == WCODE_W'(2)) ||
                     (req_width == WCODE_W'(4));
  assign needs_map = req_vm || (req_cpl > req_iopl);

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && size_ok && !needs_map) |=> (done && grant));

  assert_vm_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && size_ok && req_vm && req_limit >= ADDR_W'(32'h67)) |=> (mem_valid && !done));

  assert_offset_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && size_ok && needs_map && req_limit >= ADDR_W'(32'h67)) |=>
    (mem_valid && mem_addr == ADDR_W'(32'h66)));

  assert_short_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && size_ok && needs_map && req_limit < ADDR_W'(32'h67)) |=> (done && !grant && !mem_valid));

  assert_bad_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !size_ok) |=> (done && !grant && !mem_valid));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  assert_grant_qual_R12: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> done);
endmodule

bind port_perm_check ppc_sva #(.ADDR_W(ADDR_W), .WCODE_W(WCODE_W), .PL_W(PL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_width(req_width), .req_cpl(req_cpl), .req_iopl(req_iopl), .req_vm(req_vm),
  .req_limit(req_limit), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .done(done), .grant(grant)
);

// File: tb/sim_port_perm_check.sv
`timescale 1ns/1ps
module sim_port_perm_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_port = '0;
  logic [2:0]  req_width = '0;
  logic [1:0]  req_cpl = '0;
  logic [1:0]  req_iopl = '0;
  logic        req_vm = 1'b0;
  logic [31:0] req_limit = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic        grant;

  always #2.5 clk = ~clk;

  port_perm_check u0 (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_width(req_width), .req_cpl(req_cpl), .req_iopl(req_iopl),
    .req_vm(req_vm), .req_limit(req_limit), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .grant(grant)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  bit [7:0] mem [int];
  int  exp_q[$];     // expected read addresses; -1 = cycle with no read
  bit  m_busy = 0;
  bit  m_grant = 0;
  bit  exp_done = 0;
  bit  exp_grant = 0;
  bit  seen_done = 0;
  bit  got_grant = 0;

  function automatic int rd(int a);
    return mem.exists(a) ? int'(mem[a]) : 0;
  endfunction

  task automatic chk(string tag, int got, int want, string what);
    checks++;
    if (got != want) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, want);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // behavioural prediction of one request: read sequence and outcome
  task automatic predict();
    int w, p, lim, base, a, pair;
    bit ok;
    w = int'(req_width); p = int'(req_port); lim = int'(req_limit);
    exp_q.delete();
    if (w != 1 && w != 2 && w != 4) begin m_grant = 0; return; end
    if (!req_vm && req_cpl <= req_iopl) begin m_grant = 1; return; end
    if (lim < 'h67) begin m_grant = 0; return; end
    exp_q.push_back('h66); exp_q.push_back('h67); exp_q.push_back(-1);
    base = rd('h66) + rd('h67) * 256;
    if (strict_mode && base < 'h68) begin m_grant = 0; return; end
    a = base + p / 8;
    if (a + 1 > lim) begin m_grant = 0; return; end
    exp_q.push_back(a); exp_q.push_back(a + 1);
    pair = rd(a) + rd(a + 1) * 256;
    ok = 1;
    for (int i = 0; i < w; i++) if (((pair >> (p % 8 + i)) & 1) != 0) ok = 0;
    m_grant = ok;
  endtask

  // one clock: compare outputs against the model, drive inputs, advance the model
  task automatic step(bit want_req);
    bit em, nd, popped;
    @(negedge clk);
    cyc++;
    em = m_busy && exp_q.size() > 0 && exp_q[0] != -1;
    chk("R11", int'(req_ready), int'(!m_busy), "req_ready");
    chk("R11", int'(mem_valid), int'(em), "mem_valid");
    if (em && mem_valid) chk("R6", int'(mem_addr), exp_q[0], "mem_addr");
    chk("R12", int'(done), int'(exp_done), "done");
    if (exp_done) chk("R12", int'(grant), int'(exp_grant), "grant");
    else chk("R12", int'(grant), 0, "grant without done");
    if (done) begin seen_done = 1; got_grant = grant; end
    req_valid = want_req && !m_busy;
    mem_ready = (cyc % 3) != 1;
    mem_rdata = 8'(rd(int'(mem_addr)));
    nd = 0; popped = 0;
    if (m_busy) begin
      if (exp_q[0] == -1) begin void'(exp_q.pop_front()); popped = 1; end
      else if (mem_ready) begin void'(exp_q.pop_front()); popped = 1; end
      if (popped && exp_q.size() == 0) begin nd = 1; m_busy = 0; end
    end else if (req_valid) begin
      predict();
      if (exp_q.size() == 0) nd = 1; else m_busy = 1;
    end
    exp_done = nd;
    exp_grant = nd ? m_grant : 1'b0;
  endtask

  task automatic run_req(string tag, bit vm, int cpl, int iopl, int w, int port,
                         int lim, bit strict, bit intended);
    int n = 0;
    req_vm = vm; req_cpl = 2'(cpl); req_iopl = 2'(iopl); req_width = 3'(w);
    req_port = 16'(port); req_limit = 32'(lim); strict_mode = strict;
    seen_done = 0;
    step(1);
    while (!seen_done) begin
      step(0);
      n++;
      if (n > 300) begin
        failures++;
        $display("FAIL %s watchdog: actual=hung expected=done", tag);
        summary();
      end
    end
    chk(tag, int'(got_grant), int'(intended), "grant result");
  endtask

  task automatic set_base(int b);
    mem['h66] = 8'(b); mem['h67] = 8'(b >> 8);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL global watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", int'(done), 0, "reset done");
    chk("R11", int'(req_ready), 1, "reset req_ready");
    chk("R11", int'(mem_valid), 0, "reset mem_valid");
    rst_n = 1;

    // R1 privilege bypass, even with a tiny limit
    run_req("R1", 0, 0, 0, 1, 'h60, 0, 0, 1);
    run_req("R1", 0, 3, 3, 4, 'hFFFF, 0, 1, 1);
    // R10 unsupported size codes
    run_req("R10", 0, 3, 0, 3, 'h10, 'hE8, 0, 0);
    run_req("R10", 0, 0, 0, 0, 'h10, 'hE8, 0, 0);
    run_req("R10", 1, 3, 0, 7, 'h10, 'hE8, 0, 0);
    // R4 limit too small for the offset field
    run_req("R4", 0, 3, 0, 1, 'h10, 'h66, 0, 0);
    run_req("R4", 1, 0, 3, 1, 'h10, 'h66, 0, 0);
    // R2 VM at CPL 0 still checks the bitmap
    mem.delete(); set_base('h68);
    mem['h6C] = 8'h01;
    run_req("R2", 1, 0, 3, 1, 'h20, 'hE8, 0, 0);
    mem['h6C] = 8'h00;
    run_req("R2", 1, 0, 3, 1, 'h20, 'hE8, 0, 1);
    // R5 polarity and bit position
    mem['h70] = 8'hF7;
    run_req("R5", 0, 3, 0, 1, 'h43, 'hE8, 0, 1);
    mem['h70] = 8'h08;
    run_req("R5", 0, 3, 0, 1, 'h43, 'hE8, 0, 0);
    mem['h70] = 8'hF3;
    run_req("R5", 0, 3, 1, 2, 'h42, 'hE8, 0, 1);
    // R6 access crossing into the second byte
    mem['h69] = 8'h3F; mem['h6A] = 8'hFC;
    run_req("R6", 0, 3, 0, 4, 'h0E, 'hE8, 0, 1);
    mem['h6A] = 8'hFE;
    run_req("R6", 0, 3, 0, 4, 'h0E, 'hE8, 0, 0);
    // R7 limit boundary and the pad byte
    run_req("R7", 0, 3, 0, 1, 'h3FF, 'hE7, 0, 0);
    run_req("R7", 0, 3, 0, 1, 'h3FF, 'hE8, 0, 1);
    run_req("R7", 0, 3, 0, 1, 'h400, 'hE8, 0, 0);
    run_req("R7", 1, 0, 0, 1, 'h0, 'h67, 0, 0);
    // R8 no 16-bit wrap
    mem.delete(); set_base('h68);
    run_req("R8", 0, 3, 0, 4, 'hFFFE, 'h2068, 0, 1);
    mem['h2068] = 8'h01;
    run_req("R8", 0, 3, 0, 4, 'hFFFE, 'h2068, 0, 0);
    mem.delete(); set_base('hF000);
    mem['h0FFF] = 8'hFF;
    run_req("R8", 0, 3, 0, 1, 'hFFF8, 'h11000, 1, 1);
    // R9 strict versus permissive low base
    mem.delete(); set_base('h20);
    run_req("R9", 1, 3, 0, 1, 'h0, 'hE8, 1, 0);
    run_req("R9", 1, 3, 0, 1, 'h0, 'hE8, 0, 1);
    set_base('h68);
    run_req("R9", 1, 3, 0, 1, 'h0, 'hE8, 1, 1);
    // R3 offset re-read on every request
    mem.delete(); set_base('h68); mem['h80] = 8'hFF;
    run_req("R3", 0, 3, 0, 1, 'h0, 'hE8, 0, 1);
    set_base('h80);
    run_req("R3", 0, 3, 0, 1, 'h0, 'hE8, 0, 0);
    set_base('h68);
    run_req("R3", 0, 3, 0, 2, 'h1, 'hE8, 0, 1);

    repeat (3) step(0);
    summary();
  end
endmodule